// File: doc/BRIEF.md
# IPv4 Fast-Path Header Updater

This block sits between the ingress header queue and the dispatch logic of a packet forwarder. Each cycle it can accept one 20-byte IPv4 base header, the route result for that header and the MTU of the chosen egress link. The route result is the egress port, the next-hop link-layer address and a scheduling flow tag. The block screens the header against a fixed set of fast-path conditions. It decrements the time-to-live and adjusts the header checksum incrementally. It then emits the header with the route result attached.

The received checksum is never verified. The adjustment preserves whatever error the incoming checksum had, so a corrupt header stays detectably corrupt further downstream. A header that fails any fast-path condition is passed through unmodified. It is flagged for slow-path software with a 3-bit cause code. Option handling, fragmentation, multicast fan-out and error messages are left to that slow path.

The header is a 160-bit vector with byte 0 (version/IHL) in bits [159:152]. The fields used are version [159:156], IHL [155:152], total length [143:128], DF [110], TTL [95:88], protocol [87:80], checksum [79:64] and destination address [31:0]. Both sides use valid/ready handshakes. The pipeline advances whenever the output register is empty or being drained.

Top module: `ip_fp_update`

## Requirements
- R1: A header whose version nibble is not 4 is flagged slow with cause code 1.
- R2: A header with IHL below 5, total length below 20, or total length below IHL×4 is flagged slow with cause code 2.
- R3: A header with IHL above 5 whose lengths are otherwise sane is flagged slow with cause code 3 (options present).
- R4: A header arriving with TTL 0 or 1 is flagged slow with cause code 4.
- R5: A header whose total length exceeds the MTU input is flagged slow with cause code 5, whatever the DF bit. A length equal to the MTU stays on the fast path.
- R6: A header whose destination lies in 224.0.0.0/4 (top nibble 0xE) is flagged slow with cause code 6.
- R7: When several causes apply, the smallest cause code is reported.
- R8: A fast-path header leaves with out_slow low and cause 0. Its TTL is one lower and every other bit except the checksum field is unchanged.
- R9: On the fast path the new checksum is formed incrementally. The one's-complement sum of the ten 16-bit words of the output equals that of the input (modulo 0xFFFF). So a correct checksum stays correct and a wrong one stays wrong by the same amount.
- R10: A slow-path header leaves with every bit unchanged.
- R11: The egress port, link-layer address and flow tag supplied with a header leave together with that same header.
- R12: After reset out_valid is low and in_ready high. Headers leave in arrival order, two cycles after acceptance when out_ready stays high. While out_valid is high and out_ready low, the output holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input header valid |
| in_ready | output | 1 | Block can accept a header this cycle |
| in_hdr | input | 160 | IPv4 base header, byte 0 in the top bits |
| in_mtu | input | MTU_W (16) | MTU of the chosen egress link, bytes |
| in_port | input | PORT_W (4) | Egress port from the route result |
| in_l2 | input | L2_W (48) | Next-hop link-layer address |
| in_flow | input | FLOW_W (20) | Scheduling flow tag |
| out_valid | output | 1 | Output valid |
| out_ready | input | 1 | Downstream accepts output |
| out_hdr | output | 160 | Updated (fast) or untouched (slow) header |
| out_port | output | PORT_W (4) | Egress port |
| out_l2 | output | L2_W (48) | Link-layer address |
| out_flow | output | FLOW_W (20) | Flow tag |
| out_slow | output | 1 | Header needs slow-path handling |
| out_reason | output | 3 | Cause code: 0 none, 1 version, 2 length, 3 options, 4 TTL, 5 too big, 6 multicast |

## Verification
A cause code latched wrongly in the first stage shows up as a mismatched out_reason. It also shows up as an untouched or wrongly patched header in the same output beat, two cycles after acceptance. A bad partial checksum surfaces only as a broken one's-complement balance between input and output words. The bench therefore checks that balance on every fast-path beat, for headers with both good and corrupted checksums. A stage register that updates during a stall changes the output word or drops or repeats a header. Such a fault shows on the very next beat as a reorder against the scoreboard queue.

// File: rtl/ip_fp_pkg.sv
package ip_fp_pkg;

    localparam int HDR_W  = 160;
    localparam int WORD_W = 16;

    // cause codes, smaller value wins when several apply
    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_VER   = 3'd1,
        CAUSE_LEN   = 3'd2,
        CAUSE_OPT   = 3'd3,
        CAUSE_TTL   = 3'd4,
        CAUSE_BIG   = 3'd5,
        CAUSE_MCAST = 3'd6
    } cause_e;

    // field positions inside the 160-bit header vector
    localparam int VER_HI  = 159;
    localparam int IHL_HI  = 155;
    localparam int TLEN_HI = 143;
    localparam int TTL_HI  = 95;
    localparam int PROT_HI = 87;
    localparam int CSUM_HI = 79;
    localparam int DST_HI  = 31;

endpackage

// File: rtl/fp_ones_sum.sv
// N-term one's-complement adder, end-around carry folded after each term
module fp_ones_sum #(
    parameter int N = 2,
    parameter int W = 16
) (
    input  logic [N-1:0][W-1:0] terms,
    output logic [W-1:0]        sum
);
    logic [W-1:0] acc [N+1];

    assign acc[0] = '0;

    for (genvar i = 0; i < N; i++) begin : g_term
        logic [W:0] raw;
        assign raw        = {1'b0, acc[i]} + {1'b0, terms[i]};
        assign acc[i + 1] = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    end

    assign sum = acc[N];

endmodule

// File: rtl/fp_hdr_classify.sv
// Fast-path screening of one header; purely combinational
module fp_hdr_classify
    import ip_fp_pkg::*;
#(
    parameter int MTU_W = 16
) (
    input  logic [3:0]       ver,
    input  logic [3:0]       ihl,
    input  logic [15:0]      tot_len,
    input  logic [7:0]       ttl,
    input  logic [3:0]       dst_top,
    input  logic [MTU_W-1:0] mtu,
    output cause_e           cause
);
    localparam int CMP_W = (MTU_W > 16) ? MTU_W : 16;

    logic [CMP_W-1:0] len_x;
    logic [CMP_W-1:0] mtu_x;
    logic [15:0]      hdr_bytes;
    logic             bad_ver;
    logic             bad_len;
    logic             has_opt;
    logic             low_ttl;
    logic             too_big;
    logic             is_mcast;

    always_comb begin
        len_x     = CMP_W'(tot_len);
        mtu_x     = CMP_W'(mtu);
        hdr_bytes = {10'd0, ihl, 2'b00};
        bad_ver   = (ver != 4'd4);
        bad_len   = (ihl < 4'd5) || (tot_len < 16'd20) || (tot_len < hdr_bytes);
        has_opt   = (ihl > 4'd5);
        low_ttl   = (ttl < 8'd2);
        too_big   = (len_x > mtu_x);
        is_mcast  = (dst_top == 4'hE);

        if (bad_ver)       cause = CAUSE_VER;
        else if (bad_len)  cause = CAUSE_LEN;
        else if (has_opt)  cause = CAUSE_OPT;
        else if (low_ttl)  cause = CAUSE_TTL;
        else if (too_big)  cause = CAUSE_BIG;
        else if (is_mcast) cause = CAUSE_MCAST;
        else               cause = CAUSE_NONE;
    end

endmodule

// File: rtl/ip_fp_update.sv
// Two-stage IPv4 fast-path header updater
module ip_fp_update
    import ip_fp_pkg::*;
#(
    parameter int PORT_W = 4,
    parameter int L2_W   = 48,
    parameter int FLOW_W = 20,
    parameter int MTU_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [HDR_W-1:0]  in_hdr,
    input  logic [MTU_W-1:0]  in_mtu,
    input  logic [PORT_W-1:0] in_port,
    input  logic [L2_W-1:0]   in_l2,
    input  logic [FLOW_W-1:0] in_flow,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [HDR_W-1:0]  out_hdr,
    output logic [PORT_W-1:0] out_port,
    output logic [L2_W-1:0]   out_l2,
    output logic [FLOW_W-1:0] out_flow,
    output logic              out_slow,
    output logic [2:0]        out_reason
);
    localparam int TTLW_LO = TTL_HI - WORD_W + 1;   // word holding TTL and protocol
    localparam int CSUM_LO = CSUM_HI - WORD_W + 1;

    typedef struct packed {
        logic              vld;
        logic [HDR_W-1:0]  hdr;
        cause_e            cause;
        logic [WORD_W-1:0] part;   // ~HC + ~m, one's complement
        logic [WORD_W-1:0] mnew;   // TTL/protocol word after decrement
        logic [PORT_W-1:0] port;
        logic [L2_W-1:0]   l2;
        logic [FLOW_W-1:0] flow;
    } screen_t;

    typedef struct packed {
        logic              vld;
        logic [HDR_W-1:0]  hdr;
        cause_e            cause;
        logic [PORT_W-1:0] port;
        logic [L2_W-1:0]   l2;
        logic [FLOW_W-1:0] flow;
    } emit_t;

    screen_t sc_d, sc_q;
    emit_t   em_d, em_q;

    logic              adv;
    cause_e            in_cause;
    logic [WORD_W-1:0] in_part;
    logic [WORD_W-1:0] fin_sum;
    logic [HDR_W-1:0]  patched;

    // stage 1 helpers
    fp_hdr_classify #(.MTU_W(MTU_W)) u_cls (
        .ver     (in_hdr[VER_HI -: 4]),
        .ihl     (in_hdr[IHL_HI -: 4]),
        .tot_len (in_hdr[TLEN_HI -: 16]),
        .ttl     (in_hdr[TTL_HI -: 8]),
        .dst_top (in_hdr[DST_HI -: 4]),
        .mtu     (in_mtu),
        .cause   (in_cause)
    );

    fp_ones_sum #(.N(2), .W(WORD_W)) u_part (
        .terms ({~in_hdr[CSUM_HI -: WORD_W], ~in_hdr[TTL_HI -: WORD_W]}),
        .sum   (in_part)
    );

    // stage 2 helper: add m' and complement
    fp_ones_sum #(.N(2), .W(WORD_W)) u_fin (
        .terms ({sc_q.part, sc_q.mnew}),
        .sum   (fin_sum)
    );

    assign adv      = !em_q.vld || out_ready;
    assign in_ready = adv;

    always_comb begin
        patched = sc_q.hdr;
        patched[TTL_HI:TTLW_LO]  = sc_q.mnew;
        patched[CSUM_HI:CSUM_LO] = ~fin_sum;
    end

    always_comb begin
        sc_d = sc_q;
        em_d = em_q;
        if (adv) begin
            sc_d.vld   = in_valid;
            sc_d.hdr   = in_hdr;
            sc_d.cause = in_cause;
            sc_d.part  = in_part;
            sc_d.mnew  = {in_hdr[TTL_HI -: 8] - 8'd1, in_hdr[PROT_HI -: 8]};
            sc_d.port  = in_port;
            sc_d.l2    = in_l2;
            sc_d.flow  = in_flow;

            em_d.vld   = sc_q.vld;
            em_d.cause = sc_q.cause;
            em_d.hdr   = (sc_q.cause == CAUSE_NONE) ? patched : sc_q.hdr;
            em_d.port  = sc_q.port;
            em_d.l2    = sc_q.l2;
            em_d.flow  = sc_q.flow;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_q <= '0;
            em_q <= '0;
        end else begin
            sc_q <= sc_d;
            em_q <= em_d;
        end
    end

    assign out_valid  = em_q.vld;
    assign out_hdr    = em_q.hdr;
    assign out_port   = em_q.port;
    assign out_l2     = em_q.l2;
    assign out_flow   = em_q.flow;
    assign out_reason = em_q.cause;
    assign out_slow   = (em_q.cause != CAUSE_NONE);

endmodule

// File: rtl/ip_fp_update_chk.sv
module ip_fp_update_chk #(
    parameter int PORT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_ready,
    input logic [159:0]      out_hdr,
    input logic [PORT_W-1:0] out_port,
    input logic              out_slow,
    input logic [2:0]        out_reason
);
    // R12
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_hdr)
                                    && $stable(out_reason) && $stable(out_port));

    // R8
    fast_ttl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_slow |-> out_hdr[95:88] != 8'd0);

    // R3
    fast_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_slow |-> out_hdr[159:152] == 8'h45);

    // R6
    fast_mcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_slow |-> out_hdr[31:28] != 4'hE);

    // R7
    cause_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_reason <= 3'd6);

endmodule

bind ip_fp_update ip_fp_update_chk #(.PORT_W(PORT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_hdr    (out_hdr),
    .out_port   (out_port),
    .out_slow   (out_slow),
    .out_reason (out_reason)
);

// File: tb/tb_ip_fp_update.sv
module tb_ip_fp_update;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [159:0] in_hdr = '0;
    logic [15:0]  in_mtu = '0;
    logic [3:0]   in_port = '0;
    logic [47:0]  in_l2 = '0;
    logic [19:0]  in_flow = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [159:0] out_hdr;
    logic [3:0]   out_port;
    logic [47:0]  out_l2;
    logic [19:0]  out_flow;
    logic         out_slow;
    logic [2:0]   out_reason;

    ip_fp_update dut (.*);

    always #5 clk = ~clk;

    typedef struct {
        logic [159:0] hin;
        logic [2:0]   cause;
        logic [3:0]   port;
        logic [47:0]  l2;
        logic [19:0]  flow;
        int           acc;
        bit           lat;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int seq   = 0;
    int seen  = 0;
    bit lat_mode = 1'b1;
    bit bp_en    = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [159:0] act, input logic [159:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int hsum(input logic [159:0] h);
        int s = 0;
        for (int i = 0; i < 10; i++) s += int'(h[i*16 +: 16]);
        return s % 65535;
    endfunction

    function automatic logic [2:0] exp_cause(input logic [159:0] h, input logic [15:0] mtu);
        logic [3:0] v = h[159:156];
        logic [3:0] ihl = h[155:152];
        logic [15:0] tl = h[143:128];
        if (v != 4'd4) return 3'd1;
        if (ihl < 5 || tl < 20 || int'(tl) < int'(ihl) * 4) return 3'd2;
        if (ihl > 5) return 3'd3;
        if (h[95:88] < 8'd2) return 3'd4;
        if (tl > mtu) return 3'd5;
        if (h[31:28] == 4'hE) return 3'd6;
        return 3'd0;
    endfunction

    // driver: builds a header, pushes the expected item on acceptance
    task automatic send(input logic [3:0] ver, input logic [3:0] ihl, input logic [15:0] tl,
                        input logic [7:0] ttl, input logic [31:0] dst, input bit df,
                        input bit corrupt, input logic [15:0] mtu);
        logic [159:0] h;
        int s;
        item_t it;
        h = {ver, ihl, 8'h00, tl, 16'(seq), 1'b0, df, 14'd0, ttl, 8'd17, 16'h0000,
             32'h0A000001 + 32'(seq * 77), dst};
        s = 0;
        for (int i = 0; i < 10; i++) s += int'(h[i*16 +: 16]);
        while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
        h[79:64] = ~s[15:0] ^ (corrupt ? 16'h1234 : 16'h0000);
        @(posedge clk); #2;
        in_valid = 1'b1;
        in_hdr   = h;
        in_mtu   = mtu;
        in_port  = 4'(seq);
        in_l2    = 48'h0200_0000_0000 + 48'(seq * 3);
        in_flow  = 20'(seq * 13 + 5);
        do @(negedge clk); while (!in_ready);
        it.hin = h; it.cause = exp_cause(h, mtu);
        it.port = in_port; it.l2 = in_l2; it.flow = in_flow;
        it.acc = cyc; it.lat = lat_mode;
        q.push_back(it);
        seq++;
    endtask

    task automatic idle();
        @(posedge clk); #2;
        in_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        #2;
        out_ready = !(bp_en && ((cyc % 3) == 1 || (cyc % 7) == 0));
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            item_t it;
            logic [159:0] exph;
            string rq;
            seen++;
            if (q.size() == 0) begin
                check(1'b0, "R12", "unexpected output", out_hdr, '0);
            end else begin
                it = q.pop_front();
                case (it.cause)
                    3'd1: rq = "R1";  3'd2: rq = "R2";  3'd3: rq = "R3";
                    3'd4: rq = "R4";  3'd5: rq = "R5";  3'd6: rq = "R6";
                    default: rq = "R8";
                endcase
                check(out_reason == it.cause && out_slow == (it.cause != 0), rq, "cause",
                      160'(out_reason), 160'(it.cause));
                check(out_port == it.port && out_l2 == it.l2 && out_flow == it.flow,
                      "R11", "dispatch", {out_port, out_l2, out_flow},
                      {it.port, it.l2, it.flow});
                if (it.lat)
                    check(cyc - it.acc == 2, "R12", "latency", 160'(cyc - it.acc), 160'd2);
                if (it.cause != 0) begin
                    check(out_hdr == it.hin, "R10", "slow header", out_hdr, it.hin);
                end else begin
                    exph = it.hin;
                    exph[95:88] = it.hin[95:88] - 8'd1;
                    check({out_hdr[159:80], out_hdr[63:0]} == {exph[159:80], exph[63:0]},
                          "R8", "fast header", out_hdr, exph);
                    check(hsum(out_hdr) == hsum(it.hin), "R9", "checksum balance",
                          160'(hsum(out_hdr)), 160'(hsum(it.hin)));
                end
            end
        end
    end

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog R12 actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(out_valid == 1'b0, "R12", "out_valid after reset", 160'(out_valid), 160'd0);
        check(in_ready == 1'b1, "R12", "in_ready after reset", 160'(in_ready), 160'd1);

        // R8 R9 fast path, good checksum
        send(4, 5, 16'd60,   8'd64,  32'hC0A80101, 0, 0, 16'd1500);
        send(4, 5, 16'd20,   8'd2,   32'h0A0A0A0A, 1, 0, 16'd1500);
        send(4, 5, 16'd1400, 8'd255, 32'hDFFFFFFF, 0, 0, 16'd1500);
        // R9 corrupted checksum stays corrupted
        send(4, 5, 16'd100,  8'd30,  32'h08080808, 0, 1, 16'd1500);
        send(4, 5, 16'd576,  8'd1 + 8'd127, 32'h01020304, 0, 1, 16'd9000);
        // R1
        send(6, 5, 16'd60,   8'd64,  32'h01010101, 0, 0, 16'd1500);
        // R2
        send(4, 4, 16'd60,   8'd64,  32'h01010101, 0, 0, 16'd1500);
        send(4, 5, 16'd19,   8'd64,  32'h01010101, 0, 0, 16'd1500);
        send(4, 6, 16'd22,   8'd64,  32'h01010101, 0, 0, 16'd1500);
        // R3
        send(4, 6, 16'd100,  8'd64,  32'h01010101, 0, 0, 16'd1500);
        // R4
        send(4, 5, 16'd60,   8'd1,   32'h01010101, 0, 0, 16'd1500);
        send(4, 5, 16'd60,   8'd0,   32'h01010101, 0, 0, 16'd1500);
        // R5 both DF values, and the equality boundary
        send(4, 5, 16'd1500, 8'd64,  32'h01010101, 0, 0, 16'd1000);
        send(4, 5, 16'd1500, 8'd64,  32'h01010101, 1, 0, 16'd1000);
        send(4, 5, 16'd1000, 8'd64,  32'h01010101, 1, 0, 16'd1000);
        // R6
        send(4, 5, 16'd60,   8'd64,  32'hE0000001, 0, 0, 16'd1500);
        send(4, 5, 16'd60,   8'd64,  32'hEFFFFFFF, 0, 0, 16'd1500);
        // R7 priority
        send(6, 7, 16'd10,   8'd0,   32'hE0000001, 0, 0, 16'd8);
        send(4, 5, 16'd60,   8'd0,   32'hE0000001, 0, 0, 16'd1500);
        send(4, 7, 16'd100,  8'd1,   32'hE0000001, 0, 0, 16'd50);
        send(4, 5, 16'd900,  8'd9,   32'hE0000001, 0, 0, 16'd800);
        idle();
        repeat (6) @(posedge clk);

        // R12 backpressure stream with mixed headers
        lat_mode = 1'b0;
        bp_en = 1'b1;
        for (int k = 0; k < 60; k++) begin
            int r = int'($urandom % 16);
            send((r == 0) ? 4'd5 : 4'd4, (r == 1) ? 4'd7 : 4'd5,
                 16'(20 + ($urandom % 1600)), 8'($urandom % 8),
                 (r == 2) ? 32'hE1000000 : 32'($urandom & 32'h7FFFFFFF),
                 1'($urandom), 1'(r > 12), 16'd1500);
        end
        idle();
        bp_en = 1'b0;
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(q.size() == 0, "R12", "all headers delivered", 160'(q.size()), 160'd0);
        check(seen == seq, "R12", "output count", 160'(seen), 160'(seq));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule